// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sequences the shutdown and wake-up of a clock generator that drives several output clocks, all under the control of one input pin whose meaning changes over time. After reset the pin is a power-good indication. The first time the synchronized pin reads HIGH, the block switches it, for good, into a power-down request input. From then on, HIGH asks the block to stop the outputs and LOW asks it to bring them back.

To stop, the block passes the request into each output clock's own domain and closes that clock's gate only at a falling edge, so the gated output parks LOW without a shortened pulse. It gathers the closed-gate acknowledgements back into the reference domain. Only after every gate reports closed does it put the differential outputs into three-state and turn off the PLL and oscillator enables.

To wake up, it turns the PLL and oscillator back on and waits for the PLL lock indication. It then drives the differential outputs again and reopens each gate, again at a falling edge. A restart that runs too long without lock raises a sticky error flag. The current phase is reported on a small status output.

Top module: `clkgate_pwrseq`

## Requirements
- R1: After reset, state_o is 0, every gate_en bit is 0, pll_en, osc_en, diff_oe and lock_err are 0, and the block stays in state 0 while the pin is LOW. The state_o encoding is 0 wait-for-power-good, 1 running, 2 stopping, 3 stopped, 4 restarting.
- R2: In state 0, a pin value that has passed the two-flop synchronizer as HIGH moves the block to state 3. After that, state 0 is never entered again until reset, and the pin acts only as a power-down request.
- R3: A power-down request is accepted only when the synchronized pin reads HIGH on two consecutive rising edges of ref_clk. A HIGH lasting a single ref_clk cycle has no effect.
- R4: Each gate_en bit changes only while its out_clk is LOW, at that clock's falling edge. Every pulse of out_clk AND gate_en is therefore a full high phase.
- R5: An accepted request in state 1 moves the block to state 2. Once every gate is closed and the closure has been synchronized back, the block moves to state 3 with pll_en and osc_en LOW. pll_en and osc_en are never LOW while any gate_en bit is HIGH.
- R6: diff_oe (1 = driven, 0 = three-state) is 1 in state 1 and stays 1 through a stop that starts from state 1. It is 0 in states 0 and 3, and in state 4 until lock has been seen.
- R7: In state 3, a release (the synchronized pin LOW on two consecutive edges) moves the block to state 4 with pll_en and osc_en HIGH. After pll_lock has passed a two-flop synchronizer, diff_oe rises and the gates reopen, and the block enters state 1 once every gate is open.
- R8: If state 4 lasts LOCK_TIMEOUT ref_clk cycles without synchronized lock, lock_err rises and stays HIGH until reset. The restart keeps waiting for lock.
- R9: A release that arrives during state 2 does not cut the stop short. The block parks all outputs, passes through state 3 with the PLL off, and then restarts into state 1 without any new stimulus.
- R10: A request accepted in state 4 before lock has been seen moves the block to state 2 and then to state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the synchronizers and the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_clk | input | NUM_CLK | Output clocks that are to be gated |
| pd_pin | input | 1 | Dual-role pin: power-good first, then power-down request |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| gate_en | output | NUM_CLK | Per-clock gate enable, each changing at its own clock's falling edge |
| diff_oe | output | 1 | Differential output drive enable, 0 selects three-state |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |
| state_o | output | 3 | Current sequencer state |
| lock_err | output | 1 | Sticky flag for a restart that timed out waiting for lock |

## Verification
The bench builds the block with NUM_CLK = 3 and LOCK_TIMEOUT = 40. This lets a lock-timeout restart both fire and not fire within a few dozen reference cycles, next to a PLL model that locks 20 cycles after being enabled. The three output clocks have half periods of 3, 5 and 7 ns, none of them related to the 4 ns reference. Gate closure and reopening are therefore exercised at shifting phase offsets, and every gated pulse is measured against its full high-phase width. A one-cycle pin glitch, a release during stopping, a request during a lock-pending restart and a blocked lock all fall within this configuration.

// File: rtl/clkgate_pwrseq.sv
module clkgate_pwrseq #(
  parameter int NUM_CLK      = 3,
  parameter int LOCK_TIMEOUT = 450000
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_CLK-1:0] out_clk,
  input  logic               pd_pin,
  input  logic               pll_lock,
  output logic [NUM_CLK-1:0] gate_en,
  output logic               diff_oe,
  output logic               pll_en,
  output logic               osc_en,
  output logic [2:0]         state_o,
  output logic               lock_err
);
  localparam int         CW          = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_TIMEOUT - 1);
  localparam logic [2:0] S_WAIT      = 3'd0;
  localparam logic [2:0] S_RUN       = 3'd1;
  localparam logic [2:0] S_STOPPING  = 3'd2;
  localparam logic [2:0] S_STOPPED   = 3'd3;
  localparam logic [2:0] S_RESTART   = 3'd4;

  logic [2:0]         pin_q;
  logic [1:0]         lock_q;
  logic [NUM_CLK-1:0] park_a, park_b;
  logic [2:0]         state;
  logic               stop_req;
  logic               drv_q;
  logic               err_q;
  logic [CW-1:0]      wait_cnt;

  wire pd_req  = pin_q[2] & pin_q[1];
  wire pd_rel  = ~pin_q[2] & ~pin_q[1];
  wire locked  = lock_q[1];
  wire all_off = &park_b;
  wire all_on  = ~|park_b;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      pin_q  <= '0;
      lock_q <= '0;
      park_a <= '1;
      park_b <= '1;
    end else begin
      pin_q  <= {pin_q[1:0], pd_pin};
      lock_q <= {lock_q[0], pll_lock};
      park_a <= ~gate_en;
      park_b <= park_a;
    end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_lane
    logic [1:0] req_s;
    logic       open_q;
    always_ff @(posedge out_clk[i] or negedge rst_n)
      if (!rst_n) req_s <= 2'b11;
      else        req_s <= {req_s[0], stop_req};
    always_ff @(negedge out_clk[i] or negedge rst_n)
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= ~req_s[1];
    assign gate_en[i] = open_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_WAIT;
      stop_req <= 1'b1;
      drv_q    <= 1'b0;
      err_q    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      case (state)
        S_WAIT:
          if (pin_q[1]) state <= S_STOPPED;
        S_STOPPED:
          if (pd_rel) begin
            state    <= S_RESTART;
            wait_cnt <= '0;
          end
        S_RESTART: begin
          if (stop_req && pd_req) begin
            state <= S_STOPPING;
          end else begin
            if (locked) begin
              stop_req <= 1'b0;
              drv_q    <= 1'b1;
            end
            if (!stop_req && all_on) state <= S_RUN;
          end
          if (!locked) begin
            if (wait_cnt == CNT_LAST) err_q <= 1'b1;
            else                      wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_RUN:
          if (pd_req) begin
            state    <= S_STOPPING;
            stop_req <= 1'b1;
          end
        S_STOPPING:
          if (all_off) begin
            state <= S_STOPPED;
            drv_q <= 1'b0;
          end
        default: state <= S_WAIT;
      endcase
    end

  assign pll_en   = (state == S_RUN) | (state == S_STOPPING) | (state == S_RESTART);
  assign osc_en   = pll_en;
  assign diff_oe  = drv_q;
  assign state_o  = state;
  assign lock_err = err_q;
endmodule

// File: rtl/clkgate_pwrseq_chk.sv
module clkgate_pwrseq_chk #(
  parameter int NUM_CLK = 3
) (
  input logic               ref_clk,
  input logic               rst_n,
  input logic [NUM_CLK-1:0] out_clk,
  input logic [NUM_CLK-1:0] gate_en,
  input logic               diff_oe,
  input logic               pll_en,
  input logic               osc_en,
  input logic [2:0]         state_o,
  input logic               lock_err
);
  AST_STATE_LEGAL: assert property (@(posedge ref_clk) disable iff (!rst_n) state_o <= 3'd4); // R1
  AST_NO_RETURN_WAIT: assert property (@(posedge ref_clk) disable iff (!rst_n) (state_o != 3'd0) |=> (state_o != 3'd0)); // R2
  AST_PLL_OFF_PARKED: assert property (@(posedge ref_clk) disable iff (!rst_n) !pll_en |-> (gate_en == '0)); // R5
  AST_OSC_OFF_PARKED: assert property (@(posedge ref_clk) disable iff (!rst_n) !osc_en |-> (gate_en == '0)); // R5
  AST_RUN_EXIT: assert property (@(posedge ref_clk) disable iff (!rst_n) (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd2)); // R5
  AST_DRIVE_NEEDS_PLL: assert property (@(posedge ref_clk) disable iff (!rst_n) diff_oe |-> pll_en); // R6
  AST_ERR_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n) lock_err |=> lock_err); // R8
  AST_STOP_NO_ABORT: assert property (@(posedge ref_clk) disable iff (!rst_n) (state_o == 3'd2) |=> (state_o == 3'd2 || state_o == 3'd3)); // R9

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_edge
    always @(gate_en[i])
      if (rst_n === 1'b1)
        AST_GATE_AT_LOW: assert (out_clk[i] == 1'b0); // R4
  end
endmodule

bind clkgate_pwrseq clkgate_pwrseq_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .out_clk (out_clk),
  .gate_en (gate_en),
  .diff_oe (diff_oe),
  .pll_en  (pll_en),
  .osc_en  (osc_en),
  .state_o (state_o),
  .lock_err(lock_err)
);

// File: tb/clkgate_pwrseq_tb.sv
module clkgate_pwrseq_tb;
  localparam int NCLK = 3;
  localparam int LT   = 40;
  localparam int HALF [NCLK] = '{3, 5, 7};
  // fields: pin, expected state[2:0], pll_en, diff_oe, all gates open
  localparam logic [6:0] VEC [6] = '{
    7'b0_000_0_0_0,
    7'b1_011_0_0_0,
    7'b0_001_1_1_1,
    7'b1_011_0_0_0,
    7'b0_001_1_1_1,
    7'b0_001_1_1_1
  };

  logic ref_clk = 1'b0;
  logic rst_n;
  logic c0, c1, c2;
  logic [NCLK-1:0] out_clk;
  logic pd_pin, pll_lock, lock_block;
  logic [NCLK-1:0] gate_en;
  logic diff_oe, pll_en, osc_en, lock_err;
  logic [2:0] state_o;
  logic [NCLK-1:0] gck;

  int checks = 0, fails = 0, lock_cnt = 0;
  int runts = 0, pulses = 0, order_bad = 0;
  int n_stopping = 0, n_stopped = 0, n_pll_off = 0, n_stop_undriven = 0;
  bit done = 0;

  assign out_clk = {c2, c1, c0};
  assign gck     = out_clk & gate_en;

  always #2 ref_clk = ~ref_clk;
  initial begin c0 = 0; #1; forever #3 c0 = ~c0; end
  initial begin c1 = 0; #2; forever #5 c1 = ~c1; end
  initial begin c2 = 0; #1; forever #7 c2 = ~c2; end

  clkgate_pwrseq #(.NUM_CLK(NCLK), .LOCK_TIMEOUT(LT)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .out_clk(out_clk), .pd_pin(pd_pin),
    .pll_lock(pll_lock), .gate_en(gate_en), .diff_oe(diff_oe), .pll_en(pll_en),
    .osc_en(osc_en), .state_o(state_o), .lock_err(lock_err));

  always @(negedge ref_clk) begin
    if (!pll_en || lock_block) begin lock_cnt = 0; pll_lock = 1'b0; end
    else if (lock_cnt < 20) lock_cnt++;
    else pll_lock = 1'b1;
  end

  always @(negedge ref_clk) if (rst_n === 1'b1) begin
    if ((!pll_en || !osc_en) && gate_en != '0) order_bad++;
    if (state_o == 3'd2) n_stopping++;
    if (state_o == 3'd2 && !diff_oe) n_stop_undriven++;
    if (state_o == 3'd3) n_stopped++;
    if (!pll_en) n_pll_off++;
  end

  for (genvar g = 0; g < NCLK; g++) begin : g_mon
    time t_rise;
    bit  armed = 0;
    always @(posedge gck[g]) begin t_rise = $time; armed = 1; end
    always @(negedge gck[g]) if (armed) begin
      pulses++;
      if ($time - t_rise != time'(HALF[g])) runts++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pin(input logic v);
    @(negedge ref_clk);
    pd_pin = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int a, b, c;
    rst_n = 1'b0; pd_pin = 1'b0; lock_block = 1'b0; pll_lock = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset gates", gate_en, 0);
    chk("R1 reset pll/osc", {pll_en, osc_en}, 0);
    chk("R1 reset diff_oe", diff_oe, 0);
    chk("R1 reset lock_err", lock_err, 0);

    for (int k = 0; k < 6; k++) begin
      pin(VEC[k][6]);
      cyc(90);
      chk($sformatf("R2/R5/R7 vec%0d state", k), state_o, VEC[k][5:3]);
      chk($sformatf("R5/R7 vec%0d pll_en", k), pll_en, VEC[k][2]);
      chk($sformatf("R5/R7 vec%0d osc_en", k), osc_en, VEC[k][2]);
      chk($sformatf("R6 vec%0d diff_oe", k), diff_oe, VEC[k][1]);
      chk($sformatf("R4/R7 vec%0d gates", k), gate_en, VEC[k][0] ? 7 : 0);
    end
    chk("R8 no error on timely lock", lock_err, 0);

    // R3: one-cycle pin glitch while running is ignored
    a = n_stopping;
    pin(1'b1);
    pin(1'b0);
    cyc(40);
    chk("R3 glitch no stopping", n_stopping - a, 0);
    chk("R3 glitch still running", state_o, 1);
    chk("R3 glitch gates open", gate_en, 7);

    // R9: release during stopping
    a = n_stopped; b = n_pll_off; c = n_stop_undriven;
    pin(1'b1);
    cyc(3);
    pin(1'b0);
    cyc(150);
    chk("R9 passed through stopped", (n_stopped - a) > 0, 1);
    chk("R9 pll turned off", (n_pll_off - b) > 0, 1);
    chk("R9 back to running", state_o, 1);
    chk("R9 gates reopened", gate_en, 7);
    chk("R6 driven while stopping", n_stop_undriven - c, 0);

    // R8 / R10: restart without lock
    pin(1'b1);
    cyc(60);
    chk("R5 stopped before timeout test", state_o, 3);
    lock_block = 1'b1;
    pin(1'b0);
    cyc(LT - 5);
    chk("R7 restarting", state_o, 4);
    chk("R7 pll on in restart", {pll_en, osc_en}, 3);
    chk("R6 three-state before lock", diff_oe, 0);
    chk("R7 gates closed before lock", gate_en, 0);
    chk("R8 no error before timeout", lock_err, 0);
    cyc(15);
    chk("R8 error after timeout", lock_err, 1);
    chk("R8 still waiting", state_o, 4);
    pin(1'b1);
    cyc(40);
    chk("R10 request in restart stops", state_o, 3);
    chk("R10 pll off", pll_en, 0);
    lock_block = 1'b0;
    pin(1'b0);
    cyc(100);
    chk("R7 running after lock", state_o, 1);
    chk("R6 driven after lock", diff_oe, 1);
    chk("R8 error sticky", lock_err, 1);
    chk("R2 pin high in restart path never waits", (state_o != 0), 1);

    chk("R5 pll/osc never off with open gate", order_bad, 0);
    chk("R4 no truncated gated pulse", runts, 0);
    chk("R4 gated pulses observed", pulses > 50, 1);
    finish_run();
  end
endmodule